// File: doc/BRIEF.md
# Power Key Short/Long Press Controller

This block sits between a single power key and a host processor. The key is a contact to ground, so its raw level is active low and it bounces. The block synchronises and debounces the key, then times how long the clean key stays down. A short press sends the host one active-low suspend/resume interrupt pulse. A hold that reaches the long-press threshold instead pulls an active-low warm-restart fault line. The block then waits for the host to suspend, wakes it with an interrupt pulse, and releases the fault line.

If the host is suspended when the key goes down, the block sends a wake pulse at once. That wake then serves as the resume for the press. Any interrupt that would resume a suspended host is held back while the battery-fault input is asserted. A raw power-on reset input resets the block and, through the same two-flop release chain, the host.

The sequencer has five named states:
- ST_IDLE: waits for a press. On a press it goes to ST_TIMING, and sends a wake if the host is suspended.
- ST_TIMING: counts hold ticks. On release it goes back to ST_IDLE with a short-press pulse. On expiry it goes to ST_FAULT with the fault line low.
- ST_FAULT: waits for the host to be suspended with battery good, starts the wake pulse and goes to ST_SENDING.
- ST_SENDING: waits for the pulse to end, releases the fault line and goes to ST_DRAIN.
- ST_DRAIN: waits for key release, then returns to ST_IDLE.

Time is counted in ticks of an internal clock enable, one every `TICK_DIV` clocks. `TICK_DIV` must be at least 2.

Top module: `pwrkey_ctrl`

## Requirements
- R1: While `por_n` is low, `host_rst_n` is low and `irq_n` and `fault_n` are high. `host_rst_n` rises on the second rising clock edge after `por_n` goes high.
- R2: A raw key level is accepted only after it has been seen on `DEB_TICKS` consecutive ticks. A low level shorter than `DEB_TICKS` ticks causes no pulse and no fault.
- R3: A press while `host_suspended` is 1 and `batt_fault_n` is 1 gives one wake pulse while the key is still held.
- R4: A clean hold of fewer than `HOLD_TICKS` ticks, with the host awake, gives exactly one interrupt pulse on release, and `fault_n` stays high.
- R5: A clean hold of `HOLD_TICKS` ticks or more drives `fault_n` low, and does so once per hold, however long the key stays down.
- R6: After `fault_n` falls, no interrupt is sent until `host_suspended` is 1. `fault_n` then stays low until the wake pulse ends, and goes high one cycle after `irq_n` returns high.
- R7: While `batt_fault_n` is 0, no interrupt is started while `host_suspended` is 1. This covers the press wake, the short-press resume and the post-fault wake. The post-fault wake is sent once `batt_fault_n` returns to 1.
- R8: With the host awake, a short press sends its interrupt even while `batt_fault_n` is 0.
- R9: Every interrupt is an `irq_n` low pulse of exactly `IRQ_CYCLES` clock cycles.
- R10: If a wake was sent at the press, a short release sends no second interrupt.
- R11: When the release and the hold-expiry fall on the same tick (a clean hold of exactly `HOLD_TICKS` ticks), the warm restart wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Raw power-on reset, active low, asynchronous assert |
| key_n | input | 1 | Raw power key, low while pressed |
| host_suspended | input | 1 | 1 while the host is suspended |
| batt_fault_n | input | 1 | Low while the battery is too weak to resume |
| host_rst_n | output | 1 | Reset to the host, active low |
| irq_n | output | 1 | Suspend/resume/wake interrupt, active-low pulse |
| fault_n | output | 1 | Warm-restart command, active low |

## Verification
The key release and the hold-timer expiry can land on the same tick. In that cycle the sequencer must pick between a short-press interrupt and a warm restart. The bench provokes this by holding the raw key low for an exact whole number of tick periods, and sweeps that length through every value from one tick to past the threshold. It predicts the number of pulses and faults from the hold length alone: none below the debounce length, one pulse below the threshold, and one fault plus one wake pulse at or above it. The case of exactly `HOLD_TICKS` ticks must come out as a warm restart.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TIMING,
        ST_FAULT,
        ST_SENDING,
        ST_DRAIN
    } pk_state_e;

endpackage

// File: rtl/pwrkey_tick.sv
module pwrkey_tick #(
    parameter int TICK_DIV = 250000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (cnt_q == LAST)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/pwrkey_debounce.sv
module pwrkey_debounce #(
    parameter int DEB_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic key_raw_n,
    output logic key_down,
    output logic press_pulse
);
    localparam int CW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic [1:0]    sync_q;
    logic          key_s;
    logic          stable_n_q;
    logic [CW-1:0] cnt_q;
    logic          press_q;

    assign key_s = sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sync_q <= 2'b11;
        else
            sync_q <= {sync_q[0], key_raw_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stable_n_q <= 1'b1;
            cnt_q      <= '0;
            press_q    <= 1'b0;
        end else begin
            press_q <= 1'b0;
            if (tick) begin
                if (key_s == stable_n_q) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    stable_n_q <= key_s;
                    cnt_q      <= '0;
                    press_q    <= ~key_s;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign key_down    = ~stable_n_q;
    assign press_pulse = press_q;

    // R2: the clean key level only moves on a tick edge
    a_r2_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_down) |-> $past(tick));

    // R2: a press pulse always comes with a freshly pressed key
    a_r2_press_matches: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |-> (key_down && $past(!key_down)));
endmodule

// File: rtl/pwrkey_irq.sv
module pwrkey_irq #(
    parameter int IRQ_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic irq_n,
    output logic busy
);
    localparam int CW = $clog2(IRQ_CYCLES + 1);
    localparam int RW = $clog2(IRQ_CYCLES + 2);
    localparam logic [CW-1:0] LOAD = CW'(IRQ_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
        else if (start)
            cnt_q <= LOAD;
    end

    assign busy  = (cnt_q != '0);
    assign irq_n = (cnt_q == '0);

    // Checker: length of the current low run on irq_n
    logic [RW-1:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run_q <= '0;
        else if (irq_n)
            low_run_q <= '0;
        else if (low_run_q != {RW{1'b1}})
            low_run_q <= low_run_q + 1'b1;
    end

    // R9: each low pulse lasts exactly IRQ_CYCLES cycles
    a_r9_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> (low_run_q == RW'(IRQ_CYCLES)));

    // R9: a pulse never runs past its length
    a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q <= RW'(IRQ_CYCLES));
endmodule

// File: rtl/pwrkey_seq.sv
module pwrkey_seq
    import pwrkey_pkg::*;
#(
    parameter int HOLD_TICKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic key_down,
    input  logic press_pulse,
    input  logic host_suspended,
    input  logic batt_ok,
    input  logic pulse_busy,
    output logic pulse_start,
    output logic fault_n
);
    localparam int HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

    pk_state_e     state_q, state_d;
    logic [HW-1:0] hold_q;
    logic          woke_q;
    logic          fault_q;
    logic          blocked;
    logic          expire;

    assign blocked = host_suspended && !batt_ok;
    assign expire  = key_down && tick && (hold_q == HOLD_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (press_pulse) state_d = ST_TIMING;
            ST_TIMING: begin
                if (!key_down)   state_d = ST_IDLE;
                else if (expire) state_d = ST_FAULT;
            end
            ST_FAULT:   if (host_suspended && batt_ok && !pulse_busy) state_d = ST_SENDING;
            ST_SENDING: if (!pulse_busy) state_d = ST_DRAIN;
            ST_DRAIN:   if (!key_down) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Interrupt requests
    always_comb begin
        pulse_start = 1'b0;
        unique case (state_q)
            ST_IDLE:    pulse_start = press_pulse && host_suspended && batt_ok && !pulse_busy;
            ST_TIMING:  pulse_start = !key_down && !woke_q && !blocked && !pulse_busy;
            ST_FAULT:   pulse_start = host_suspended && batt_ok && !pulse_busy;
            ST_SENDING: pulse_start = 1'b0;
            ST_DRAIN:   pulse_start = 1'b0;
            default:    pulse_start = 1'b0;
        endcase
    end

    // Registered outputs and hold timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            woke_q  <= 1'b0;
            fault_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    hold_q <= '0;
                    if (press_pulse)
                        woke_q <= host_suspended && batt_ok && !pulse_busy;
                end
                ST_TIMING: begin
                    if (expire)
                        fault_q <= 1'b0;
                    else if (key_down && tick)
                        hold_q <= hold_q + 1'b1;
                end
                ST_SENDING: if (!pulse_busy) fault_q <= 1'b1;
                ST_FAULT, ST_DRAIN: ;
                default: fault_q <= 1'b1;
            endcase
        end
    end

    assign fault_n = fault_q;

    // R7: nothing is started toward a suspended host while the battery is weak
    a_r7_batt_block: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_start && host_suspended) |-> batt_ok);

    // R5: the fault line only falls at a tick with the key held, during timing
    a_r5_fault_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> ($past(state_q == ST_TIMING) && $past(key_down) && $past(tick)));

    // R6: the fault line is released only once the wake pulse has finished
    a_r6_release_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> ($past(state_q == ST_SENDING) && !$past(pulse_busy)));

    // R5: the fault line is low exactly in the fault and sending states
    a_r5_fault_states: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n) == (state_q == ST_FAULT || state_q == ST_SENDING));
endmodule

// File: rtl/pwrkey_ctrl.sv
module pwrkey_ctrl #(
    parameter int TICK_DIV   = 250000,
    parameter int DEB_TICKS  = 20,
    parameter int HOLD_TICKS = 5000,
    parameter int IRQ_CYCLES = 64
) (
    input  logic clk,
    input  logic por_n,
    input  logic key_n,
    input  logic host_suspended,
    input  logic batt_fault_n,
    output logic host_rst_n,
    output logic irq_n,
    output logic fault_n
);
    logic [1:0] rst_q;
    logic       rst_n;
    logic       tick;
    logic       key_down;
    logic       press_pulse;
    logic       pulse_start;
    logic       pulse_busy;

    // One reset for host and block: asynchronous assert, two-flop release
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            rst_q <= 2'b00;
        else
            rst_q <= {rst_q[0], 1'b1};
    end
    assign rst_n      = rst_q[1];
    assign host_rst_n = rst_n;

    pwrkey_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pwrkey_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .key_raw_n   (key_n),
        .key_down    (key_down),
        .press_pulse (press_pulse)
    );

    pwrkey_seq #(.HOLD_TICKS(HOLD_TICKS)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .key_down       (key_down),
        .press_pulse    (press_pulse),
        .host_suspended (host_suspended),
        .batt_ok        (batt_fault_n),
        .pulse_busy     (pulse_busy),
        .pulse_start    (pulse_start),
        .fault_n        (fault_n)
    );

    pwrkey_irq #(.IRQ_CYCLES(IRQ_CYCLES)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pulse_start),
        .irq_n (irq_n),
        .busy  (pulse_busy)
    );

    // R1: while the host is held in reset both command lines are idle
    a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        !host_rst_n |-> (irq_n && fault_n));

    // R6: with the fault line low, an interrupt only starts toward a suspended host
    a_r6_wait_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && $fell(irq_n)) |-> $past(host_suspended));
endmodule

// File: tb/pwrkey_ctrl_bench.sv
module pwrkey_ctrl_bench;
    localparam int D    = 4;
    localparam int DEB  = 3;
    localparam int HOLD = 8;
    localparam int IRQ  = 5;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic key_n = 1'b1;
    logic man_susp = 1'b0;
    logic auto_host = 1'b0;
    logic auto_susp = 1'b0;
    logic batt_fault_n = 1'b1;
    logic host_suspended;
    logic host_rst_n, irq_n, fault_n;

    int nchk = 0;
    int nfail = 0;
    int pulses = 0;
    int faults = 0;
    int low_run = 0;
    logic irq_prev = 1'b1;
    logic fault_prev = 1'b1;
    logic done = 1'b0;

    always #2 clk = ~clk;

    assign host_suspended = auto_host ? auto_susp : man_susp;

    pwrkey_ctrl #(
        .TICK_DIV(D), .DEB_TICKS(DEB), .HOLD_TICKS(HOLD), .IRQ_CYCLES(IRQ)
    ) u_pwrkey_ctrl (
        .clk(clk), .por_n(por_n), .key_n(key_n),
        .host_suspended(host_suspended), .batt_fault_n(batt_fault_n),
        .host_rst_n(host_rst_n), .irq_n(irq_n), .fault_n(fault_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: count pulses and faults, check pulse width (R9)
    always @(negedge clk) begin
        if (!irq_n) low_run <= low_run + 1;
        if (irq_n && !irq_prev) begin
            pulses <= pulses + 1;
            chk("R9 pulse width", low_run, IRQ);
            low_run <= 0;
        end
        if (!fault_n && fault_prev) faults <= faults + 1;
        irq_prev   <= irq_n;
        fault_prev <= fault_n;
    end

    // Host model: suspends on a fault edge, wakes on an interrupt
    always @(negedge clk) begin
        if (!auto_host)                  auto_susp <= 1'b0;
        else if (!irq_n)                 auto_susp <= 1'b0;
        else if (!fault_n && fault_prev) auto_susp <= 1'b1;
    end

    task automatic clear_counts();
        @(negedge clk);
        pulses = 0;
        faults = 0;
    endtask

    task automatic hold_key(input int nticks);
        key_n = 1'b0;
        repeat (nticks * D) @(negedge clk);
        key_n = 1'b1;
    endtask

    task automatic settle();
        repeat ((DEB + 3) * D + IRQ + 20) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        // R1: reset state and release timing
        repeat (5) @(negedge clk);
        chk("R1 host_rst_n in reset", host_rst_n, 0);
        chk("R1 irq_n in reset", irq_n, 1);
        chk("R1 fault_n in reset", fault_n, 1);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1 host_rst_n after one edge", host_rst_n, 0);
        @(negedge clk);
        chk("R1 host_rst_n after two edges", host_rst_n, 1);
        repeat (10) @(negedge clk);

        // Sweep of hold length, host awake, battery good (R2 R4 R5 R6 R11)
        auto_host = 1'b1;
        for (int n = 1; n <= HOLD + 3; n++) begin
            int ep, ef;
            string tag;
            ep = (n < DEB) ? 0 : 1;
            ef = (n >= HOLD) ? 1 : 0;
            if (n < DEB)        tag = "R2";
            else if (n < HOLD)  tag = "R4";
            else if (n == HOLD) tag = "R11";
            else                tag = "R5";
            clear_counts();
            hold_key(n);
            settle();
            chk({tag, " pulses"}, pulses, ep);
            chk({tag, " faults"}, faults, ef);
            chk("R6 fault released", fault_n, 1);
        end

        // R5: a very long hold faults only once
        clear_counts();
        hold_key(3 * HOLD);
        settle();
        chk("R5 once per hold", faults, 1);
        chk("R6 one wake after fault", pulses, 1);
        auto_host = 1'b0;

        // R3 R10: wake at press, no second pulse on short release
        man_susp = 1'b1;
        clear_counts();
        hold_key(HOLD - 1);
        chk("R3 wake during hold", pulses, 1);
        settle();
        chk("R10 no second pulse", pulses, 1);
        chk("R10 no fault", faults, 0);

        // R7: suspended host, weak battery, short press
        batt_fault_n = 1'b0;
        clear_counts();
        hold_key(DEB + 2);
        settle();
        chk("R7 short press blocked", pulses, 0);

        // R8: awake host, weak battery, short press still interrupts
        man_susp = 1'b0;
        clear_counts();
        hold_key(DEB + 2);
        settle();
        chk("R8 suspend request sent", pulses, 1);

        // R7 R6: long hold with suspended host and weak battery
        man_susp = 1'b1;
        clear_counts();
        hold_key(HOLD + 4);
        chk("R7 fault asserted", fault_n, 0);
        settle();
        chk("R7 wake blocked", pulses, 0);
        chk("R7 fault held while blocked", fault_n, 0);
        batt_fault_n = 1'b1;
        repeat (IRQ + 10) @(negedge clk);
        chk("R7 wake after battery good", pulses, 1);
        chk("R6 fault released after wake", fault_n, 1);
        chk("R5 single fault", faults, 1);
        man_susp = 1'b0;
        settle();

        // R6 R1: fault waits for suspend; power-on reset clears it
        clear_counts();
        hold_key(HOLD + 2);
        repeat (20) @(negedge clk);
        chk("R6 no irq before suspend", pulses, 0);
        chk("R6 fault waiting", fault_n, 0);
        por_n = 1'b0;
        #1;
        chk("R1 fault cleared by reset", fault_n, 1);
        chk("R1 host reset asserted", host_rst_n, 0);
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle after reset", irq_n, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule